// File: doc/BRIEF.md
# Half-Bridge Gate Protection Controller

This block is the digital control and protection logic for one half-bridge leg. It takes a turn-on command level for the low-side and for the high-side switch. It also takes an overcurrent or desaturation comparator flag from each side, and undervoltage flags for each side's positive and negative supply. It produces a registered gate-enable for each switch, a clamp enable per side that shorts that side's sense input to its Kelvin ground, and an active-low combined fault output. Deadtime must be supplied upstream, because the block inserts none. Its interlock only prevents the two switches from being commanded on together.

Each side runs its own protection. An overcurrent seen while that gate is on, after a one-cycle blanking window, latches a fault. The latched fault holds that gate off until the command for that side rises again. An undervoltage forces the gate off for as long as it lasts and is not remembered. A fault on one side never shuts down the other side; the other side only sees it in the combined fault report. After reset both gates stay off until the first cycle in which all four supply flags report good.

Every pin is a plain level. No data flows through the block, so it has no valid/ready handshake and applies no back-pressure. The comparator flags are treated as asynchronous and are synchronized inside the block. Commands and supply flags are taken as synchronous to the clock.

Top module: `hb_gate_guard`

## Requirements
- R1: With no fault, lockout or interlock block, each gate enable equals its own command as sampled at the previous clock edge, so it has one cycle of latency. A low command turns the gate off at the next edge.
- R2: From reset until the first edge at which all four undervoltage flags are low, both gate enables stay 0. After that edge the block stays armed.
- R3: An undervoltage flag (positive or negative) on a side forces that side's gate off at the next edge. When the flag clears, the gate follows a still-high command at the next edge with no new command edge needed.
- R4: The clamp enable of a side is the inverse of its gate enable in every cycle. Both are registered on the same edge, so the clamp drops in the same cycle the gate rises. Reset values are clamp 1 and gate 0.
- R5: A comparator flag is ignored while the side's gate is off. It is also ignored in the first cycle the gate is on (blanking). A flag of one cycle seen later latches the fault, and the gate goes off three edges after the raw flag was sampled, because of two synchronizer stages and the latch.
- R6: A latched overcurrent keeps that gate off, even with the command held high or lowered. Only a rising edge of that side's command clears it, and the gate then turns on at that same edge.
- R7: The two gate enables are never 1 together. A side that holds its command keeps its state when the other command rises. The other side stays off until the holding command drops. If both commands rise on the same edge, both stay off until one drops. This holds while a side is off for a fault.
- R8: No deadtime: when one command drops and the other is already high at the same edge, the first gate goes off and the second goes on at the same edge.
- R9: fault_n is registered. It is 0 after an edge at which either side has a latched overcurrent or any undervoltage flag is high, and 1 otherwise. Its reset value is 1.
- R10: A fault on the high side, whether latched overcurrent or undervoltage, does not stop the low-side gate from following its command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_lo | input | 1 | Low-side turn-on command level |
| cmd_hi | input | 1 | High-side turn-on command level |
| oc_lo_raw | input | 1 | Low-side overcurrent/desaturation comparator flag (asynchronous) |
| oc_hi_raw | input | 1 | High-side overcurrent/desaturation comparator flag (asynchronous) |
| uv_pos_lo | input | 1 | Low-side positive supply undervoltage |
| uv_neg_lo | input | 1 | Low-side negative supply undervoltage |
| uv_pos_hi | input | 1 | High-side positive supply undervoltage |
| uv_neg_hi | input | 1 | High-side negative supply undervoltage |
| gate_lo | output | 1 | Low-side gate enable |
| gate_hi | output | 1 | High-side gate enable |
| clamp_lo | output | 1 | Low-side sense-input clamp enable |
| clamp_hi | output | 1 | High-side sense-input clamp enable |
| fault_n | output | 1 | Combined fault, active low |

## Verification
The assertions check several rules on every cycle. They check that the two gates are never on together and that each clamp is the inverse of its gate. They check that an unarmed block keeps both gates off, and that a low command or an undervoltage turns the gate off at the next edge. They also check that a latched fault without a rising command keeps the gate off, and that any undervoltage pulls fault_n low. Other behaviour can only be shown by the bench's timed scenarios. These are the three-edge latency of a single-cycle comparator pulse, the blanking cycle that swallows a pulse, and the clearing of a latched fault by a fresh rising command. They also include the rules for which side holds when commands overlap, the handover without deadtime, and a high-side fault that leaves the low side running.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int NUM_SIDES = 2;
  localparam int SIDE_LO   = 0;
  localparam int SIDE_HI   = 1;

  function automatic int peer_of(input int side);
    return (side == SIDE_LO) ? SIDE_HI : SIDE_LO;
  endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/hb_interlock.sv
module hb_interlock
  import hb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SIDES-1:0] cmd,
  output logic [NUM_SIDES-1:0] own_d
);
  logic [NUM_SIDES-1:0] own_q;

  // A side keeps ownership while its command holds; it gains ownership
  // only when the peer command is low. Simultaneous rises grant nobody.
  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_own
    localparam int PEER = peer_of(g);
    assign own_d[g] = cmd[g] & (own_q[g] | ~cmd[PEER]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= '0;
    else        own_q <= own_d;
  end

  a_r7_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(own_q) <= 1);
endmodule

// File: rtl/hb_side_ctrl.sv
module hb_side_ctrl #(
  parameter int BLANK_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,
  input  logic uv,
  input  logic oc_sync,
  input  logic own_next,
  input  logic armed_next,
  output logic gate,
  output logic clamp,
  output logic latch_next
);
  localparam int CW = $clog2(BLANK_CYCLES + 1);

  logic          cmd_q;
  logic          oc_latch;
  logic [CW-1:0] on_cnt;
  logic          blank_done;
  logic          cmd_rise;
  logic          oc_set;
  logic          gate_d;

  assign cmd_rise   = cmd & ~cmd_q;
  assign blank_done = (on_cnt == CW'(BLANK_CYCLES));
  // Sense honoured only while on and past the blanking window
  assign oc_set     = oc_sync & gate & blank_done;
  assign latch_next = cmd_rise ? 1'b0 : (oc_latch | oc_set);
  assign gate_d     = own_next & ~latch_next & ~uv & armed_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= 1'b0;
      oc_latch <= 1'b0;
      gate     <= 1'b0;
      clamp    <= 1'b1;
      on_cnt   <= '0;
    end else begin
      cmd_q    <= cmd;
      oc_latch <= latch_next;
      gate     <= gate_d;
      clamp    <= ~gate_d;
      if (!gate)             on_cnt <= '0;
      else if (!blank_done)  on_cnt <= on_cnt + CW'(1);
    end
  end

  a_r4_clamp_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    clamp == !gate);
  a_r3_uv_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    uv |=> !gate);
  a_r1_low_cmd_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd |=> !gate);
  a_r6_latch_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_latch && !cmd_rise) |=> !gate);
endmodule

// File: rtl/hb_gate_guard.sv
module hb_gate_guard
  import hb_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int BLANK_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_lo,
  input  logic cmd_hi,
  input  logic oc_lo_raw,
  input  logic oc_hi_raw,
  input  logic uv_pos_lo,
  input  logic uv_neg_lo,
  input  logic uv_pos_hi,
  input  logic uv_neg_hi,
  output logic gate_lo,
  output logic gate_hi,
  output logic clamp_lo,
  output logic clamp_hi,
  output logic fault_n
);
  logic [NUM_SIDES-1:0] cmd_v, uv_v, oc_raw_v, oc_sync_v;
  logic [NUM_SIDES-1:0] own_d, gate_v, clamp_v, latch_d;
  logic                 armed_q, armed_d;

  assign cmd_v[SIDE_LO]    = cmd_lo;
  assign cmd_v[SIDE_HI]    = cmd_hi;
  assign uv_v[SIDE_LO]     = uv_pos_lo | uv_neg_lo;
  assign uv_v[SIDE_HI]     = uv_pos_hi | uv_neg_hi;
  assign oc_raw_v[SIDE_LO] = oc_lo_raw;
  assign oc_raw_v[SIDE_HI] = oc_hi_raw;

  hb_sync #(.WIDTH(NUM_SIDES), .STAGES(SYNC_STAGES)) u_oc_sync (
    .clk(clk), .rst_n(rst_n), .async_in(oc_raw_v), .sync_out(oc_sync_v));

  hb_interlock u_lock (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_v), .own_d(own_d));

  // Power-up hold-off: arm once every supply has been good together
  assign armed_d = armed_q | ~(|uv_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      fault_n <= 1'b1;
    end else begin
      armed_q <= armed_d;
      fault_n <= ~((|latch_d) | (|uv_v));
    end
  end

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    hb_side_ctrl #(.BLANK_CYCLES(BLANK_CYCLES)) u_side (
      .clk(clk), .rst_n(rst_n),
      .cmd(cmd_v[g]), .uv(uv_v[g]), .oc_sync(oc_sync_v[g]),
      .own_next(own_d[g]), .armed_next(armed_d),
      .gate(gate_v[g]), .clamp(clamp_v[g]), .latch_next(latch_d[g]));
  end

  assign gate_lo  = gate_v[SIDE_LO];
  assign gate_hi  = gate_v[SIDE_HI];
  assign clamp_lo = clamp_v[SIDE_LO];
  assign clamp_hi = clamp_v[SIDE_HI];

  a_r7_never_both_on: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_lo && gate_hi));
  a_r2_unarmed_off: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (!gate_lo && !gate_hi));
  a_r9_uv_reports: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_pos_lo || uv_neg_lo || uv_pos_hi || uv_neg_hi) |=> !fault_n);
endmodule

// File: tb/hb_gate_guard_tb.sv
module hb_gate_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_lo = 0, cmd_hi = 0, oc_lo_raw = 0, oc_hi_raw = 0;
  logic uv_pos_lo = 1, uv_neg_lo = 1, uv_pos_hi = 1, uv_neg_hi = 1;
  logic gate_lo, gate_hi, clamp_lo, clamp_hi, fault_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    logic  gl;
    logic  gh;
    logic  fn;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  hb_gate_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
    .oc_lo_raw(oc_lo_raw), .oc_hi_raw(oc_hi_raw),
    .uv_pos_lo(uv_pos_lo), .uv_neg_lo(uv_neg_lo),
    .uv_pos_hi(uv_pos_hi), .uv_neg_hi(uv_neg_hi),
    .gate_lo(gate_lo), .gate_hi(gate_hi), .clamp_lo(clamp_lo),
    .clamp_hi(clamp_hi), .fault_n(fault_n));

  function automatic void cmp(string tag, string what, logic act, logic expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, expv);
    end
  endfunction

  // Driver: apply one cycle of inputs, push the outputs expected after the edge
  // uvv = {uv_neg_hi, uv_pos_hi, uv_neg_lo, uv_pos_lo}
  task automatic step(input logic cl, input logic ch, input logic ol,
                      input logic oh, input logic [3:0] uvv,
                      input logic egl, input logic egh, input logic efn,
                      input string tag);
    exp_t e;
    @(negedge clk);
    cmd_lo = cl; cmd_hi = ch; oc_lo_raw = ol; oc_hi_raw = oh;
    {uv_neg_hi, uv_pos_hi, uv_neg_lo, uv_pos_lo} = uvv;
    e.gl = egl; e.gh = egh; e.fn = efn; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: sample after the edge, pop and compare
  always @(posedge clk) begin
    #2;
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      cmp(e.tag, "gate_lo", gate_lo, e.gl);
      cmp(e.tag, "gate_hi", gate_hi, e.gh);
      cmp("R4", "clamp_lo", clamp_lo, ~e.gl);
      cmp("R4", "clamp_hi", clamp_hi, ~e.gh);
      cmp(e.tag, "fault_n", fault_n, e.fn);
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R4", "reset gate_lo", gate_lo, 1'b0);
    cmp("R4", "reset gate_hi", gate_hi, 1'b0);
    cmp("R4", "reset clamp_lo", clamp_lo, 1'b1);
    cmp("R4", "reset clamp_hi", clamp_hi, 1'b1);
    cmp("R9", "reset fault_n", fault_n, 1'b1);
    rst_n = 1'b1;
    // R2 power-up hold-off
    step(1,0,0,0,4'b1111, 0,0,0, "R2");
    step(1,0,0,0,4'b1111, 0,0,0, "R2");
    step(1,0,0,0,4'b0000, 1,0,1, "R2");
    step(0,0,0,0,4'b0000, 0,0,1, "R1");
    step(0,1,0,0,4'b0000, 0,1,1, "R1");
    // R7 holding side keeps, R8 handover without deadtime
    step(1,1,0,0,4'b0000, 0,1,1, "R7");
    step(1,0,0,0,4'b0000, 1,0,1, "R8");
    step(0,0,0,0,4'b0000, 0,0,1, "R1");
    step(1,1,0,0,4'b0000, 0,0,1, "R7");
    step(1,0,0,0,4'b0000, 1,0,1, "R7");
    step(0,0,0,0,4'b0000, 0,0,1, "R1");
    // R3 high-side undervoltage after arming, R10 locality
    step(0,1,0,0,4'b0100, 0,0,0, "R3");
    step(0,1,0,0,4'b0000, 0,1,1, "R3");
    step(1,0,0,0,4'b1000, 1,0,0, "R10");
    step(1,0,0,0,4'b0000, 1,0,1, "R9");
    step(0,0,0,0,4'b0000, 0,0,1, "R1");
    step(1,0,0,0,4'b0000, 1,0,1, "R1");
    step(1,0,0,0,4'b0010, 0,0,0, "R3");
    step(1,0,0,0,4'b0000, 1,0,1, "R3");
    step(0,0,0,0,4'b0000, 0,0,1, "R1");
    // R5 comparator ignored while off
    step(0,0,1,0,4'b0000, 0,0,1, "R5");
    step(0,0,1,0,4'b0000, 0,0,1, "R5");
    step(0,0,1,0,4'b0000, 0,0,1, "R5");
    step(0,0,0,0,4'b0000, 0,0,1, "R5");
    step(0,0,0,0,4'b0000, 0,0,1, "R5");
    // R5 latency and R6 latch held until a new rising command
    step(1,0,0,0,4'b0000, 1,0,1, "R1");
    step(1,0,1,0,4'b0000, 1,0,1, "R5");
    step(1,0,0,0,4'b0000, 1,0,1, "R5");
    step(1,0,0,0,4'b0000, 0,0,0, "R5");
    step(1,0,0,0,4'b0000, 0,0,0, "R6");
    step(0,0,0,0,4'b0000, 0,0,0, "R6");
    step(1,0,0,0,4'b0000, 1,0,1, "R6");
    step(0,0,0,0,4'b0000, 0,0,1, "R1");
    // high-side overcurrent, low side still runs (R10)
    step(0,1,0,0,4'b0000, 0,1,1, "R1");
    step(0,1,0,1,4'b0000, 0,1,1, "R5");
    step(0,1,0,0,4'b0000, 0,1,1, "R5");
    step(0,1,0,0,4'b0000, 0,0,0, "R5");
    step(1,0,0,0,4'b0000, 1,0,0, "R10");
    step(0,1,0,0,4'b0000, 0,1,1, "R6");
    step(0,0,0,0,4'b0000, 0,0,1, "R1");
    // R5 blanking swallows a pulse in the first on cycle
    step(0,0,1,0,4'b0000, 0,0,1, "R5");
    step(1,0,0,0,4'b0000, 1,0,1, "R5");
    step(1,0,0,0,4'b0000, 1,0,1, "R5");
    step(1,0,0,0,4'b0000, 1,0,1, "R5");
    step(0,0,0,0,4'b0000, 0,0,1, "R1");
    // R7 interlock during a fault
    step(0,1,0,0,4'b0000, 0,1,1, "R1");
    step(0,1,0,1,4'b0000, 0,1,1, "R5");
    step(0,1,0,0,4'b0000, 0,1,1, "R5");
    step(0,1,0,0,4'b0000, 0,0,0, "R5");
    step(1,1,0,0,4'b0000, 0,0,0, "R7");
    step(1,0,0,0,4'b0000, 1,0,0, "R7");
    step(0,0,0,0,4'b0000, 0,0,0, "R9");
    step(0,1,0,0,4'b0000, 0,1,1, "R6");
    step(0,0,0,0,4'b0000, 0,0,1, "R1");
    wait (sb_q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule